// File: doc/BRIEF.md
# Conditional Branch Resolver

This block decides whether a conditional branch of a 24-bit instruction is taken and computes the address of the next instruction. The decode stage supplies a branch form selector, the instruction's fields (a 2-bit mode, two 4-bit register/selector fields, an 8-bit and a 12-bit offset), the program counter of the branch and the two register operand values that have already been read. One cycle after a valid request, the block presents a registered taken flag and the next program counter to the fetch logic.

Four forms are covered. The first compares the first operand against zero and uses the long offset. The second and third compare the first operand against a constant picked from one of two fixed lookup tables (signed or unsigned) and use the short offset. The fourth selects a register-register test, a mask test or a single-bit test through the selector field, whose top bit flips the sense of the test.

Top module: `branch_resolve`

## Requirements
- R1: A request with `req_valid` high produces `res_valid` high on the following clock edge; without a request `res_valid` falls and `res_taken` and `res_pc` keep their last values.
- R2: Form 0 (`req_form` = 0) compares the first operand with zero; `fld_m` 0 is equal, 1 is not-equal, 2 is signed less-than, 3 is signed greater-or-equal.
- R3: A taken form-0 branch goes to PC + 4 plus the sign-extended 12-bit offset.
- R4: Form 1 compares the first operand with a signed constant chosen by `fld_r` from the list (index 0 to 15) -1, 1, 2, 3, 4, 5, 6, 7, 8, 10, 12, 16, 32, 64, 128, 256, with `fld_m` choosing the test as in R2.
- R5: Form 2 compares unsigned against the same list except index 0 is 32768 and index 1 is 65536; `fld_m` = 2 gives unsigned less-than and every other value unsigned greater-or-equal.
- R6: In form 3, `fld_r[3]` = 0 takes the branch when the selected test holds and `fld_r[3]` = 1 when it fails.
- R7: In form 3, `fld_r[2:0]` 0 tests (s AND t) == 0, 1 tests s == t, 2 tests signed s < t, 3 tests unsigned s < t, 4 tests (s AND t) == t.
- R8: In form 3 with `fld_r[2:0]` = 5, the test holds when bit `src_t[4:0]` of s is clear.
- R9: In form 3 with `fld_r[2:0]` 6 or 7, the test holds when bit {`fld_r[0]`, `fld_t`} of s is clear.
- R10: A taken branch of forms 1 to 3 goes to PC + 4 plus the sign-extended 8-bit offset; any branch not taken goes to PC + 3.
- R11: While reset is asserted, `res_valid`, `res_taken` and `res_pc` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe |
| req_form | input | 2 | Branch form 0..3 |
| fld_m | input | 2 | Mode field |
| fld_r | input | 4 | Selector / constant index field |
| fld_t | input | 4 | Register field, low bits of bit index in tests 6/7 |
| off8 | input | 8 | Short branch offset |
| off12 | input | 12 | Long branch offset |
| cur_pc | input | 32 | Address of the branch |
| src_s | input | 32 | First operand value |
| src_t | input | 32 | Second operand value |
| res_valid | output | 1 | Result strobe |
| res_taken | output | 1 | Branch taken |
| res_pc | output | 32 | Next program counter |

## Verification
Directed requests put the first operand exactly on, just below and just above every table constant and zero, which separates equal from less-than and signed from unsigned ordering, and distinguishes the two tables at indices 0 and 1. Bit tests hit bits 0, 15, 16 and 31 so that a wrong index source or a dropped high index bit shows up, and offsets at their most negative and most positive values expose sign-extension mistakes. A long random stream with biased operands (equal pairs, masks, sign-boundary values) and idle gaps covers the polarity bit and output hold across all forms.

// File: rtl/branch_resolve.sv
module branch_resolve #(
  parameter int DW   = 32,
  parameter int OFFL = 12,
  parameter int OFFS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [1:0]      req_form,
  input  logic [1:0]      fld_m,
  input  logic [3:0]      fld_r,
  input  logic [3:0]      fld_t,
  input  logic [OFFS-1:0] off8,
  input  logic [OFFL-1:0] off12,
  input  logic [DW-1:0]   cur_pc,
  input  logic [DW-1:0]   src_s,
  input  logic [DW-1:0]   src_t,
  output logic            res_valid,
  output logic            res_taken,
  output logic [DW-1:0]   res_pc
);

  localparam int BW = $clog2(DW);
  localparam logic [1:0] F_ZERO = 2'd0;
  localparam logic [1:0] F_CSGN = 2'd1;
  localparam logic [1:0] F_CUNS = 2'd2;
  localparam logic [1:0] F_REG  = 2'd3;

  function automatic logic [DW-1:0] k_signed(input logic [3:0] idx);
    case (idx)
      4'd0:    return '1;
      4'd9:    return DW'(10);
      4'd10:   return DW'(12);
      4'd11:   return DW'(16);
      4'd12, 4'd13, 4'd14, 4'd15:
               return DW'(1) << (idx - 4'd7);
      default: return DW'(idx);
    endcase
  endfunction

  function automatic logic [DW-1:0] k_unsigned(input logic [3:0] idx);
    case (idx)
      4'd0:    return DW'(32768);
      4'd1:    return DW'(65536);
      default: return k_signed(idx);
    endcase
  endfunction

  logic [DW-1:0] opnd_b;
  logic          is_eq, is_slt, is_ult;
  logic [BW-1:0] bit_ix;
  logic          bit_clr;
  logic          reg_test;
  logic          cond;
  logic [DW-1:0] offs;
  logic [DW-1:0] tgt_pc, seq_pc, nxt_pc;

  always_comb begin
    case (req_form)
      F_ZERO:  opnd_b = '0;
      F_CSGN:  opnd_b = k_signed(fld_r);
      F_CUNS:  opnd_b = k_unsigned(fld_r);
      default: opnd_b = src_t;
    endcase
  end

  assign is_eq  = (src_s == opnd_b);
  assign is_slt = ($signed(src_s) < $signed(opnd_b));
  assign is_ult = (src_s < opnd_b);

  assign bit_ix  = (fld_r[2:0] == 3'd5) ? src_t[BW-1:0] : BW'({fld_r[0], fld_t});
  assign bit_clr = ~src_s[bit_ix];

  always_comb begin
    case (fld_r[2:0])
      3'd0:    reg_test = ((src_s & src_t) == '0);
      3'd1:    reg_test = is_eq;
      3'd2:    reg_test = is_slt;
      3'd3:    reg_test = is_ult;
      3'd4:    reg_test = ((src_s & src_t) == src_t);
      default: reg_test = bit_clr;
    endcase
  end

  always_comb begin
    case (req_form)
      F_ZERO, F_CSGN:
        case (fld_m)
          2'd0:    cond = is_eq;
          2'd1:    cond = ~is_eq;
          2'd2:    cond = is_slt;
          default: cond = ~is_slt;
        endcase
      F_CUNS:  cond = (fld_m == 2'd2) ? is_ult : ~is_ult;
      default: cond = reg_test ^ fld_r[3];
    endcase
  end

  assign offs   = (req_form == F_ZERO) ? {{(DW-OFFL){off12[OFFL-1]}}, off12}
                                       : {{(DW-OFFS){off8[OFFS-1]}}, off8};
  assign tgt_pc = cur_pc + DW'(4) + offs;
  assign seq_pc = cur_pc + DW'(3);
  assign nxt_pc = cond ? tgt_pc : seq_pc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_taken <= 1'b0;
      res_pc    <= '0;
    end else begin
      res_valid <= req_valid;
      if (req_valid) begin
        res_taken <= cond;
        res_pc    <= nxt_pc;
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid); // R1

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!res_valid && $stable(res_taken) && $stable(res_pc))); // R1

  AST_ZERO_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_form == F_ZERO && fld_m == 2'd0) |=> (res_taken == ($past(src_s) == '0))); // R2

  AST_LONG_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_form == F_ZERO) |=>
      (!res_taken || res_pc == $past(cur_pc) + DW'(4) + {{(DW-OFFL){$past(off12[OFFL-1])}}, $past(off12)})); // R3

  AST_SHORT_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_form != F_ZERO) |=>
      (!res_taken || res_pc == $past(cur_pc) + DW'(4) + {{(DW-OFFS){$past(off8[OFFS-1])}}, $past(off8)})); // R10

  AST_FALLTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (res_taken || res_pc == $past(cur_pc) + DW'(3))); // R10

  AST_POLARITY_EQ: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_form == F_REG && fld_r == 4'd9) |=> (res_taken == ($past(src_s) != $past(src_t)))); // R6

endmodule

// File: tb/test_branch_resolve.sv
`timescale 1ns/1ps
module test_branch_resolve;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_form = '0;
  logic [1:0]  fld_m = '0;
  logic [3:0]  fld_r = '0;
  logic [3:0]  fld_t = '0;
  logic [7:0]  off8 = '0;
  logic [11:0] off12 = '0;
  logic [31:0] cur_pc = '0;
  logic [31:0] src_s = '0;
  logic [31:0] src_t = '0;
  logic        res_valid, res_taken;
  logic [31:0] res_pc;

  branch_resolve i_branch_resolve (
    .clk, .rst_n, .req_valid, .req_form, .fld_m, .fld_r, .fld_t,
    .off8, .off12, .cur_pc, .src_s, .src_t,
    .res_valid, .res_taken, .res_pc
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  int          tab_s [16] = '{-1, 1, 2, 3, 4, 5, 6, 7, 8, 10, 12, 16, 32, 64, 128, 256};
  int unsigned tab_u [16] = '{32768, 65536, 2, 3, 4, 5, 6, 7, 8, 10, 12, 16, 32, 64, 128, 256};

  bit          e_valid = 0, e_taken = 0;
  bit [31:0]   e_pc = 0;
  string       e_tag = "R11";

  function automatic void ref_model(output bit tk, output bit [31:0] np, output string tag);
    int          si, ti;
    bit          hold;
    int          ix;
    si = src_s;
    ti = src_t;
    hold = 0;
    tag = "";
    case (req_form)
      2'd0: begin
        case (fld_m)
          2'd0: hold = (si == 0);
          2'd1: hold = (si != 0);
          2'd2: hold = (si < 0);
          default: hold = (si >= 0);
        endcase
        tag = "R2 R3";
      end
      2'd1: begin
        case (fld_m)
          2'd0: hold = (si == tab_s[fld_r]);
          2'd1: hold = (si != tab_s[fld_r]);
          2'd2: hold = (si < tab_s[fld_r]);
          default: hold = (si >= tab_s[fld_r]);
        endcase
        tag = "R4 R10";
      end
      2'd2: begin
        hold = (fld_m == 2'd2) ? (src_s < tab_u[fld_r]) : (src_s >= tab_u[fld_r]);
        tag = "R5 R10";
      end
      default: begin
        case (fld_r[2:0])
          3'd0: begin hold = ((src_s & src_t) == 0); tag = "R7 R6 R10"; end
          3'd1: begin hold = (src_s == src_t); tag = "R7 R6 R10"; end
          3'd2: begin hold = (si < ti); tag = "R7 R6 R10"; end
          3'd3: begin hold = (src_s < src_t); tag = "R7 R6 R10"; end
          3'd4: begin hold = ((src_s & src_t) == src_t); tag = "R7 R6 R10"; end
          3'd5: begin ix = src_t % 32; hold = (src_s[ix] == 1'b0); tag = "R8 R6 R10"; end
          default: begin ix = fld_r[0] * 16 + fld_t; hold = (src_s[ix] == 1'b0); tag = "R9 R6 R10"; end
        endcase
        if (fld_r[3]) hold = !hold;
      end
    endcase
    tk = hold;
    if (!hold) np = cur_pc + 3;
    else if (req_form == 2'd0) np = cur_pc + 4 + 32'($signed(off12));
    else np = cur_pc + 4 + 32'($signed(off8));
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      e_valid = 0; e_taken = 0; e_pc = 0; e_tag = "R11";
    end else begin
      e_valid = req_valid;
      if (req_valid) ref_model(e_taken, e_pc, e_tag);
      else e_tag = "R1";
    end
  end

  always @(negedge clk) begin
    if (cyc >= 1 && !done) begin
      checks++;
      if (res_valid !== e_valid || res_taken !== e_taken || res_pc !== e_pc) begin
        fails++;
        $display("FAIL %s: got valid=%0b taken=%0b pc=%08h, expected valid=%0b taken=%0b pc=%08h",
                 e_tag, res_valid, res_taken, res_pc, e_valid, e_taken, e_pc);
      end
    end
  end

  task automatic send(input bit [1:0] f, input bit [1:0] m, input bit [3:0] r, input bit [3:0] t,
                      input bit [7:0] o8, input bit [11:0] o12, input bit [31:0] pc,
                      input bit [31:0] s, input bit [31:0] tv);
    @(negedge clk);
    req_valid = 1; req_form = f; fld_m = m; fld_r = r; fld_t = t;
    off8 = o8; off12 = o12; cur_pc = pc; src_s = s; src_t = tv;
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 0;
    src_s = $urandom; cur_pc = $urandom;
  endtask

  function automatic bit [31:0] pick_s(input bit [3:0] r);
    case ($urandom_range(0, 5))
      0: return 0;
      1: return 32'hFFFF_FFFF;
      2: return tab_u[r] + $urandom_range(0, 2) - 1;
      3: return 32'(tab_s[r]) + $urandom_range(0, 2) - 1;
      4: return 32'h8000_0000 ^ $urandom_range(0, 1);
      default: return $urandom;
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R2, R3: zero compares and long offset extremes
    for (int m = 0; m < 4; m++) begin
      send(0, 2'(m), 0, 0, 0, 12'h800, 32'h0000_1000, 0, 0);
      send(0, 2'(m), 0, 0, 0, 12'h7FF, 32'h0000_2000, 32'h8000_0000, 0);
      send(0, 2'(m), 0, 0, 0, 12'hFFF, 32'h0000_3000, 1, 0);
    end
    idle();
    // R4, R5: every table entry on and around its value
    for (int r = 0; r < 16; r++)
      for (int d = -1; d <= 1; d++)
        for (int m = 0; m < 4; m++) begin
          send(1, 2'(m), 4'(r), 0, 8'h80, 0, 32'h10, 32'(tab_s[r] + d), 0);
          send(2, 2'(m), 4'(r), 0, 8'h7F, 0, 32'h20, tab_u[r] + d, 0);
        end
    // R7, R6: register tests incl. sign boundary
    for (int r = 0; r < 16; r++) begin
      if (r % 8 >= 5) continue;
      send(3, 0, 4'(r), 0, 8'h05, 0, 32'h100, 32'h8000_0000, 32'h0000_0001);
      send(3, 0, 4'(r), 0, 8'hFB, 0, 32'h100, 32'h0F0F_0000, 32'h0F0F_0000);
      send(3, 0, 4'(r), 0, 8'h40, 0, 32'h100, 32'h0000_00F0, 32'h0000_000F);
      send(3, 0, 4'(r), 0, 8'h40, 0, 32'h100, 32'h0000_0001, 32'h8000_0000);
    end
    // R8, R9: bit tests at 0, 15, 16, 31
    for (int b = 0; b < 4; b++) begin
      int bits [4] = '{0, 15, 16, 31};
      for (int pol = 0; pol < 2; pol++) begin
        send(3, 0, 4'(5 + 8 * pol), 0, 8'h10, 0, 32'hFFFF_FFF0, 32'(1) << bits[b], 32'(bits[b]) | 32'hFFFF_FF00);
        send(3, 0, 4'(5 + 8 * pol), 0, 8'h10, 0, 32'h44, ~(32'(1) << bits[b]), 32'(bits[b]));
        send(3, 0, 4'(6 + (bits[b] / 16) + 8 * pol), 4'(bits[b] % 16), 8'h90, 0, 32'h80, 32'(1) << bits[b], 0);
        send(3, 0, 4'(6 + (bits[b] / 16) + 8 * pol), 4'(bits[b] % 16), 8'h90, 0, 32'h80, ~(32'(1) << bits[b]), 0);
      end
    end
    idle(); idle();
    // random stream, R1 hold via idle gaps
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 7) == 0) idle();
      else begin
        bit [3:0] r;
        bit [31:0] s, tv;
        r = 4'($urandom);
        s = pick_s(r);
        case ($urandom_range(0, 3))
          0: tv = s;
          1: tv = s & $urandom;
          2: tv = $urandom_range(0, 40);
          default: tv = $urandom;
        endcase
        send(2'($urandom), 2'($urandom), r, 4'($urandom), 8'($urandom), 12'($urandom),
             $urandom, s, tv);
      end
    end
    idle(); idle();
    @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule